// File: doc/BRIEF.md
# Interpolating Degamma Lookup Table

This block is the linearising stage that runs before colour conversion. It handles one colour channel, so a full pipe places one copy per channel. Each pixel sample is an unsigned fixed-point number with 3 integer bits and 24 fractional bits.

For a sample below 1.0, the top seven fractional bits pick one of 128 segments. The result is interpolated linearly between the two table entries that bound that segment. For a sample of 1.0 or more, the result is one of three extended-range entries, chosen by the integer part, with no interpolation.

The table holds 131 entries. Entries 0 to 127 keep only 24 fractional bits. Entries 128 to 130 keep 3 integer bits and 24 fractional bits, and entry 128 also serves as the upper endpoint of the last segment. Software fills the table through two registers on a simple write strobe: a position register and an entry register. The position register can step forward on its own after each entry write.

Top module: `degamma_interp`

## Requirements
- R1: After reset, out_valid is low and every table entry reads as zero, so every sample produces 0.
- R2: A write with reg_sel=0 and reg_wdata[8]=0 loads the position from reg_wdata[7:0], clamped to 130, and turns stepping off.
- R3: A write with reg_sel=0 and reg_wdata[8]=1 turns stepping on and leaves the position unchanged, whatever bits [7:0] hold.
- R4: A write with reg_sel=1 stores reg_wdata into the entry at the current position. At positions 0 to 127 only bits [23:0] are kept and the upper three bits read as zero. At positions 128 to 130 all 27 bits are kept.
- R5: With stepping on, each entry write advances the position by one. The write that stores entry 130 locks the port, and later entry writes are ignored until a position write with bit 8 clear.
- R6: With stepping off, repeated entry writes all land on the same position, and the last one wins.
- R7: For a sample with bits [26:24]=0, let k=bits[23:17] and w=bits[16:0]. The result is E[k] + floor(((E[k+1]-E[k])*w + 2^16) / 2^17), which is the interpolated value rounded to nearest with halves rounding up.
- R8: For a sample whose integer part is 1 or 2, the result is E[128] or E[129]. For an integer part of 3 to 7, the result is E[130]. The entry is passed through unchanged.
- R9: out_valid rises exactly two cycles after in_valid is sampled high, and carries that sample's result. When no sample was accepted in that cycle, out_valid is low.
- R10: A sample accepted on the same edge as an entry write sees the old table contents. Samples accepted on later edges see the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the position register, 1 selects the entry register |
| reg_wdata | input | 27 | Write data: position in [7:0] and stepping enable in [8], or an entry value |
| in_valid | input | 1 | Sample valid |
| in_pix | input | 27 | Input sample, unsigned 3.24 |
| out_valid | output | 1 | Result valid |
| out_pix | output | 27 | Result, unsigned 3.24 |

## Verification
Each result is due on the second rising edge after its sample is accepted. A register write changes the table at the edge that samples it, so it affects only samples accepted on later edges.

The bench keeps a behavioural model made of plain integer arrays. On every rising edge the model moves its own two-stage valid and data pair forward, then applies that edge's write. On every falling edge it compares out_valid and out_pix against the model. The result timing and the same-edge write ordering are therefore checked on every cycle, not only at chosen points.

// File: rtl/degamma_pkg.sv
`timescale 1ns/1ps
// degamma_pkg: shared default dimensions for the interpolating degamma stage.
// Assumes the interpolated range is a power-of-two segment count and that the
// extended-range entries follow the last interpolation endpoint directly.
package degamma_pkg;
    localparam int DG_FRAC_W   = 24;  // fractional bits of samples and entries
    localparam int DG_INT_W    = 3;   // integer bits of samples and wide entries
    localparam int DG_SEG_W    = 7;   // segment select bits (128 segments)
    localparam int DG_N_EXT    = 3;   // extended-range entries
    localparam int DG_AUTO_BIT = 8;   // stepping enable bit in a position write
endpackage

// File: rtl/dg_regport.sv
`timescale 1ns/1ps
// dg_regport: position / entry programming port.
// Holds the write position, the stepping flag and the lock flag. It turns
// entry writes into table write strobes. Assumes the data width covers the
// position field and the stepping bit.
module dg_regport #(
    parameter int DW       = 27,
    parameter int IDX_W    = 8,
    parameter int LAST_IDX = 130,
    parameter int AUTO_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic             tbl_we,
    output logic [IDX_W-1:0] tbl_addr,
    output logic [IDX_W-1:0] idx_q,
    output logic             auto_q,
    output logic             full_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

    logic             pos_wr;
    logic             ent_wr;
    logic [IDX_W-1:0] pos_field;
    logic [IDX_W-1:0] pos_clamped;

    // Decode the strobe into position and entry writes, and clamp the field.
    always_comb begin
        pos_wr      = reg_we && !reg_sel;
        ent_wr      = reg_we &&  reg_sel;
        pos_field   = reg_wdata[IDX_W-1:0];
        pos_clamped = (pos_field > LAST) ? LAST : pos_field;
        tbl_we      = ent_wr && !full_q;
        tbl_addr    = idx_q;
    end

    // Position, stepping and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            auto_q <= 1'b0;
            full_q <= 1'b0;
        end else if (pos_wr) begin
            if (reg_wdata[AUTO_BIT]) begin
                auto_q <= 1'b1;
            end else begin
                auto_q <= 1'b0;
                full_q <= 1'b0;
                idx_q  <= pos_clamped;
            end
        end else if (tbl_we && auto_q) begin
            if (idx_q == LAST) begin
                full_q <= 1'b1;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/dg_table.sv
`timescale 1ns/1ps
// dg_table: coefficient storage with one write port and three combinational
// read ports: the segment base, the segment top and the extended-range entry.
// Narrow entries drop their integer bits on write. Assumes the write address
// never exceeds the last entry.
module dg_table #(
    parameter int FRAC_W = 24,
    parameter int INT_W  = 3,
    parameter int SEG_W  = 7,
    parameter int N_EXT  = 3,
    parameter int IDX_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         waddr,
    input  logic [INT_W+FRAC_W-1:0]  wdata,
    input  logic [SEG_W-1:0]         rd_seg,
    input  logic [INT_W-1:0]         rd_int,
    output logic [INT_W+FRAC_W-1:0]  ent_lo,
    output logic [INT_W+FRAC_W-1:0]  ent_hi,
    output logic [INT_W+FRAC_W-1:0]  ent_ext
);
    localparam int PIX_W = INT_W + FRAC_W;
    localparam int N_SEG = 1 << SEG_W;
    localparam int DEPTH = N_SEG + N_EXT;

    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] wdata_m;
    logic [IDX_W-1:0] lo_addr;
    logic [IDX_W-1:0] hi_addr;
    logic [IDX_W-1:0] ext_addr;

    // Narrow entries keep only their fractional bits.
    always_comb begin
        if (waddr < IDX_W'(N_SEG)) wdata_m = {{INT_W{1'b0}}, wdata[FRAC_W-1:0]};
        else                       wdata_m = wdata;
    end

    // Table storage, cleared to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata_m;
        end
    end

    // Segment base and segment top addresses.
    always_comb begin
        lo_addr = IDX_W'(rd_seg);
        hi_addr = lo_addr + IDX_W'(1);
    end

    // Extended entry select: the integer part, capped at the entry count.
    generate
        if (N_EXT == 1) begin : g_ext_single
            always_comb ext_addr = IDX_W'(N_SEG);
        end else begin : g_ext_multi
            logic [INT_W-1:0] int_cap;
            always_comb begin
                int_cap  = (rd_int >= INT_W'(N_EXT)) ? INT_W'(N_EXT) : rd_int;
                ext_addr = IDX_W'(N_SEG - 1) + IDX_W'(int_cap);
            end
        end
    endgenerate

    // Read ports.
    always_comb begin
        ent_lo  = mem[lo_addr];
        ent_hi  = mem[hi_addr];
        ent_ext = mem[ext_addr];
    end
endmodule

// File: rtl/dg_interp.sv
`timescale 1ns/1ps
// dg_interp: two-stage interpolator.
// Stage 1 captures the operands read from the table together with the weight.
// Stage 2 forms a + round((b-a)*w / 2^WGT_W), or passes the extended entry
// through, and saturates to the output range. Assumes the table read ports are
// already addressed by the current sample.
module dg_interp #(
    parameter int FRAC_W = 24,
    parameter int INT_W  = 3,
    parameter int SEG_W  = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [INT_W-1:0]               in_int,
    input  logic [FRAC_W-SEG_W-1:0]        in_wgt,
    input  logic [INT_W+FRAC_W-1:0]        ent_lo,
    input  logic [INT_W+FRAC_W-1:0]        ent_hi,
    input  logic [INT_W+FRAC_W-1:0]        ent_ext,
    output logic                           out_valid,
    output logic [INT_W+FRAC_W-1:0]        out_pix
);
    localparam int PIX_W  = INT_W + FRAC_W;
    localparam int WGT_W  = FRAC_W - SEG_W;
    localparam int PROD_W = PIX_W + WGT_W + 2;

    logic              s1_v;
    logic              s1_ext;
    logic [PIX_W-1:0]  s1_a;
    logic [PIX_W-1:0]  s1_b;
    logic [WGT_W-1:0]  s1_w;

    logic signed [PROD_W-1:0] diff_x;
    logic signed [PROD_W-1:0] wgt_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    logic signed [PROD_W-1:0] step;
    logic signed [PROD_W-1:0] sum;
    logic [PIX_W-1:0]         interp;
    logic [PIX_W-1:0]         result;

    // Stage 1: capture the operands and the weight of an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_ext <= 1'b0;
            s1_a   <= '0;
            s1_b   <= '0;
            s1_w   <= '0;
        end else begin
            s1_v <= in_valid;
            if (in_valid) begin
                s1_ext <= (in_int != '0);
                s1_a   <= (in_int != '0) ? ent_ext : ent_lo;
                s1_b   <= ent_hi;
                s1_w   <= in_wgt;
            end
        end
    end

    // Signed blend with round-half-up, then saturation to the output range.
    always_comb begin
        diff_x = $signed({{(PROD_W-PIX_W){1'b0}}, s1_b}) - $signed({{(PROD_W-PIX_W){1'b0}}, s1_a});
        wgt_x  = $signed({{(PROD_W-WGT_W){1'b0}}, s1_w});
        prod   = diff_x * wgt_x;
        rnd    = prod + (PROD_W'(1) <<< (WGT_W - 1));
        step   = rnd >>> WGT_W;
        sum    = $signed({{(PROD_W-PIX_W){1'b0}}, s1_a}) + step;
        if (sum[PROD_W-1])                  interp = '0;
        else if (|sum[PROD_W-2:PIX_W])      interp = '1;
        else                                interp = sum[PIX_W-1:0];
        result = s1_ext ? s1_a : interp;
    end

    // Stage 2: output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_v;
            if (s1_v) out_pix <= result;
        end
    end
endmodule

// File: rtl/degamma_interp.sv
`timescale 1ns/1ps
// degamma_interp: single-channel interpolating degamma stage.
// Joins the programming port, the coefficient table and the two-stage
// interpolator. Assumes samples are unsigned INT_W.FRAC_W values and that one
// copy is placed per colour channel.
module degamma_interp
    import degamma_pkg::*;
#(
    parameter int FRAC_W   = DG_FRAC_W,
    parameter int INT_W    = DG_INT_W,
    parameter int SEG_W    = DG_SEG_W,
    parameter int N_EXT    = DG_N_EXT,
    parameter int AUTO_BIT = DG_AUTO_BIT,
    localparam int PIX_W   = INT_W + FRAC_W,
    localparam int WGT_W   = FRAC_W - SEG_W,
    localparam int DEPTH   = (1 << SEG_W) + N_EXT,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [PIX_W-1:0] reg_wdata,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    logic             tbl_we;
    logic [IDX_W-1:0] tbl_addr;
    logic [IDX_W-1:0] idx_q;
    logic             auto_q;
    logic             full_q;
    logic [PIX_W-1:0] ent_lo;
    logic [PIX_W-1:0] ent_hi;
    logic [PIX_W-1:0] ent_ext;

    dg_regport #(
        .DW(PIX_W), .IDX_W(IDX_W), .LAST_IDX(DEPTH - 1), .AUTO_BIT(AUTO_BIT)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .idx_q(idx_q), .auto_q(auto_q), .full_q(full_q)
    );

    dg_table #(
        .FRAC_W(FRAC_W), .INT_W(INT_W), .SEG_W(SEG_W), .N_EXT(N_EXT), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(reg_wdata),
        .rd_seg(in_pix[FRAC_W-1:WGT_W]), .rd_int(in_pix[PIX_W-1:FRAC_W]),
        .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_ext(ent_ext)
    );

    dg_interp #(
        .FRAC_W(FRAC_W), .INT_W(INT_W), .SEG_W(SEG_W)
    ) u_interp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_int(in_pix[PIX_W-1:FRAC_W]), .in_wgt(in_pix[WGT_W-1:0]),
        .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_ext(ent_ext),
        .out_valid(out_valid), .out_pix(out_pix)
    );
endmodule

// File: rtl/dg_checker.sv
`timescale 1ns/1ps
// dg_checker: protocol and timing properties of degamma_interp, attached by
// bind. Assumes a synchronous active-low reset.
module dg_checker #(
    parameter int DW       = 27,
    parameter int IDX_W    = 8,
    parameter int LAST_IDX = 130,
    parameter int AUTO_BIT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_sel,
    input logic [DW-1:0]    reg_wdata,
    input logic             in_valid,
    input logic             out_valid,
    input logic [IDX_W-1:0] idx,
    input logic             auto_on,
    input logic             locked
);
    logic [1:0] since_rst;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R9: the result flag follows the sample flag by exactly two edges.
    a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2: the position never leaves the table.
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(LAST_IDX));

    // R3: enabling stepping keeps the position.
    a_r3_auto_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel && reg_wdata[AUTO_BIT]) |=> ($stable(idx) && auto_on));

    // R5: once locked, entry writes neither move nor unlock the port.
    a_r5_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && reg_we && reg_sel) |=> ($stable(idx) && locked));

    // R6: without stepping, entry writes keep the position.
    a_r6_no_step_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_on && reg_we && reg_sel) |=> $stable(idx));
endmodule

bind degamma_interp dg_checker #(
    .DW(PIX_W), .IDX_W(IDX_W), .LAST_IDX(DEPTH - 1), .AUTO_BIT(AUTO_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .out_valid(out_valid),
    .idx(u_port.idx_q), .auto_on(u_port.auto_q), .locked(u_port.full_q)
);

// File: tb/test_degamma_interp.sv
`timescale 1ns/1ps
// test_degamma_interp: behavioural reference model compared on every cycle.
module test_degamma_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [26:0] reg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [26:0] in_pix = '0;
    logic        out_valid;
    logic [26:0] out_pix;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string phase = "R1";

    // Model state.
    longint tbl [131];
    int     m_idx;
    bit     m_auto, m_full;
    bit     mv1, mv2;
    longint me1, me2;

    always #2 clk = ~clk;

    degamma_interp i_degamma_interp (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic longint expect_of(longint p);
        longint ip, k, w, a, b;
        ip = p >> 24;
        if (ip != 0) return tbl[(ip >= 3) ? 130 : 127 + ip];
        k = (p >> 17) & 127;
        w = p & 'h1FFFF;
        a = tbl[k];
        b = tbl[k + 1];
        return a + (((b - a) * w + 65536) >>> 17);
    endfunction

    // Reference model: advance the result pipeline, then apply the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 131; i++) tbl[i] = 0;
            m_idx = 0; m_auto = 0; m_full = 0;
            mv1 = 0; mv2 = 0; me1 = 0; me2 = 0;
        end else begin
            mv2 = mv1; me2 = me1;
            mv1 = in_valid;
            if (in_valid) me1 = expect_of(longint'(in_pix));
            if (reg_we) begin
                if (!reg_sel) begin
                    if (reg_wdata[8]) m_auto = 1;
                    else begin
                        m_auto = 0; m_full = 0;
                        m_idx = (int'(reg_wdata[7:0]) > 130) ? 130 : int'(reg_wdata[7:0]);
                    end
                end else if (!m_full) begin
                    tbl[m_idx] = (m_idx < 128) ? longint'(reg_wdata[23:0]) : longint'(reg_wdata);
                    if (m_auto) begin
                        if (m_idx == 130) m_full = 1;
                        else m_idx++;
                    end
                end
            end
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (out_valid !== mv2 || (mv2 && out_pix !== 27'(me2))) begin
                mismatched++;
                $display("FAIL %s: actual valid=%0b pix=%0h expected valid=%0b pix=%0h",
                         phase, out_valid, out_pix, mv2, 27'(me2));
            end
        end
    end

    task automatic step(bit we, bit sel, longint wd, bit iv, longint px);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = 27'(wd);
        in_valid = iv; in_pix = 27'(px);
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask
    task automatic wpos(longint v);  step(1, 0, v, 0, 0); endtask
    task automatic wdat(longint v);  step(1, 1, v, 0, 0); endtask
    task automatic pix(longint v);   step(0, 0, 0, 1, v); endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL R9 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; zero table gives zero results.
        phase = "R1";
        compared++;
        if (out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: actual valid=%0b expected valid=0", out_valid);
        end
        pix(27'h0ABCDEF); pix(27'h1000000); pix(27'h7FFFFFF); idle(3);

        // R2/R3/R4/R5: ramp load with stepping, junk in the position field.
        phase = "R3";
        wpos(0);
        wpos(27'h100 | 27'h55);
        phase = "R4";
        for (int i = 0; i < 128; i++) begin
            longint v = (longint'(i) * 64'hFFFFFF) / 128;
            if (i == 3) v = v | (5 << 24);
            wdat(v);
        end
        wdat(1 << 24);
        wdat((2 << 24) + 123);
        wdat((7 << 24) + 'hFFFFFF);
        phase = "R5";
        wdat(27'h1234);
        wdat(27'h0);
        idle(2);
        pix(3 << 24); pix(7 << 24);

        // R7: interpolation across segments and weights.
        phase = "R7";
        pix(0); pix(27'h01FFFF); pix(27'h010000); pix(27'h060000 | 27'h0ABCD);
        pix(27'hFE0000); pix(27'hFFFFFF); pix(27'h7F1234);
        // R8: extended range.
        phase = "R8";
        pix(27'h1000000); pix(27'h1FFFFFF); pix(27'h2000000); pix(27'h3000001); pix(27'h5ABCDEF);
        // R9: gaps and back-to-back samples.
        phase = "R9";
        pix(27'h123456); idle(1); pix(27'h234567); pix(27'h345678); idle(4);

        // R6: no stepping, last write wins; descending segment.
        phase = "R6";
        wpos(10); wdat(27'hFFFFFF); wdat(27'h000100); idle(1);
        pix((10 << 17) | 27'h1FFFF); pix((9 << 17) | 27'h10000); pix((10 << 17) | 27'h00001);
        // R2: position beyond the table clamps to the last entry.
        phase = "R2";
        wpos(200); wdat(27'h4ABCDEF); idle(1); pix(6 << 24); pix(2 << 24);
        wpos(27'h0FF); wdat(27'h3000000); idle(1); pix(3 << 24);

        // R10: sample on the same edge as a write sees the old entry.
        phase = "R10";
        wpos(5);
        step(1, 1, 27'h800000, 1, (5 << 17) | 27'h8000);
        pix((5 << 17) | 27'h8000);
        step(1, 1, 27'h100, 1, (4 << 17) | 27'h1FFFF);
        pix((4 << 17) | 27'h1FFFF);
        idle(3);

        // R7: random table and sample mix.
        phase = "R7";
        for (int n = 0; n < 1500; n++) begin
            int r = int'($urandom_range(0, 9));
            if (r == 0) wpos($urandom_range(0, 140) | (($urandom_range(0, 3) == 0) ? 'h100 : 0));
            else if (r < 3) wdat($urandom & 27'h7FFFFFF);
            else if (r < 8) pix(($urandom_range(0, 4) == 0) ? ($urandom & 27'h7FFFFFF) : ($urandom & 27'hFFFFFF));
            else idle(1);
        end
        idle(3);
        wpos(0);
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule